// File: doc/BRIEF.md
# Exception Control Register File

This block keeps the architectural state a processor needs to enter and leave an exception handler: a status word holding the interrupt mask bits and a three-level stack of privilege/enable pairs, a cause word holding the exception code and the pending hardware interrupt bits, the saved exception PC, and the faulting address. The datapath raises a synchronous exception request with a 5-bit code, the current PC and the memory address involved. Five hardware interrupt lines feed sticky pending bits. The block decides in each cycle whether an exception is taken. When one is taken it updates all the registers on the same clock edge. One cycle later it pulses a take strobe and presents the fixed handler address as the redirect PC.

Handler software reaches the four registers through a numbered access port. Writes take effect on the next edge. Reads return, one cycle after the number is presented, the value the register held before that edge. A return command pops the privilege/enable stack.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After a synchronous active-high reset, registers 8, 12, 13 and 14 read 0 and `take_exc` is 0.
- R2: A software write to register 12 (status) stores bits 15:8 (mask) and bits 5:0 (stack). All other bits read 0, so writing all ones reads back 0x0000FF3F.
- R3: When an exception is taken, status bits 5:0 become the old bits 3:0 shifted up by two, with bits 1:0 cleared. The mask bits are unchanged.
- R4: When an exception is taken, register 14 (exception PC) becomes `cur_pc` minus 4. In the following cycle `take_exc` is 1 for exactly one cycle and `redirect_pc` is 0x80000180.
- R5: Cause bits 6:2 (register 13) hold the code of the last taken exception. The code is the requested code for a synchronous exception and 0 for an external interrupt. Software cannot write these bits.
- R6: Register 8 (bad address) loads `fault_addr` only when a taken exception has code 4 (load/fetch address error) or code 5 (store address error). Any other code leaves it unchanged.
- R7: Hardware line i sets cause bit 10+i. The bit stays set even while interrupts are masked or disabled. A software write of 1 to that bit of register 13 clears it. An arrival in the same cycle wins over the clear.
- R8: An external interrupt is taken only when status bit 0 is 1 and some pending bit 10+i has status mask bit 10+i set.
- R9: A return command with no exception in the same cycle sets status bits 3:0 to the old bits 5:2 and leaves bits 5:4 unchanged.
- R10: When a synchronous request and an enabled, unmasked pending interrupt fall in the same cycle, the synchronous code is recorded and the interrupt stays pending.
- R11: The read port returns, one cycle after `csr_rsel` is presented, the value the selected register held before that clock edge. Any number other than 8, 12, 13 or 14 reads 0. Register 14 is fully writable by software.
- R12: In a cycle that takes an exception, a return command and software writes to status and exception PC are discarded. A return command takes precedence over a software status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | Synchronous exception request from the datapath |
| sync_code | input | 5 | Exception code for the request |
| cur_pc | input | 32 | PC value that the datapath has already advanced by 4 |
| fault_addr | input | 32 | Memory address of the faulting reference |
| hw_irq | input | 5 | Hardware interrupt request lines |
| rfe | input | 1 | Return-from-exception command |
| csr_wr | input | 1 | Software register write enable |
| csr_wsel | input | 5 | Register number for the write |
| csr_wdata | input | 32 | Write data |
| csr_rsel | input | 5 | Register number for the read |
| csr_rdata | output | 32 | Registered read data |
| take_exc | output | 1 | Pulses for one cycle after an exception is taken |
| redirect_pc | output | 32 | Handler entry address, valid while `take_exc` is 1 |

## Verification
Several functions can fall in the same cycle and need checking together. A synchronous request can coincide with an enabled, unmasked pending interrupt. The bench provokes this by unmasking a pending line and raising a breakpoint request on the very next cycle. The recorded code must be the synchronous one, the pending bit must survive, and cleared enables must prevent a second entry. The same approach pairs a return command, and separately a software status write, with an exception request. It also pairs a pending-bit clear with a new arrival on that line. A behavioural reference model is compared against the outputs on every clock to judge each case.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W     = 5;
  localparam int MASK_W     = 8;
  localparam int STACK_W    = 6;
  localparam int MASK_LO    = 8;
  localparam int CODE_LO    = 2;
  localparam int PEND_LO    = 10;
  localparam int HW_MASK_LO = PEND_LO - MASK_LO;

  localparam int SEL_BADADDR = 8;
  localparam int SEL_STATUS  = 12;
  localparam int SEL_CAUSE   = 13;
  localparam int SEL_EPC     = 14;

  localparam logic [CODE_W-1:0] EC_EXT_INT    = 5'd0;
  localparam logic [CODE_W-1:0] EC_ADDR_LOAD  = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADDR_STORE = 5'd5;
  localparam logic [CODE_W-1:0] EC_SYSCALL    = 5'd8;
  localparam logic [CODE_W-1:0] EC_BREAK      = 5'd9;
  localparam logic [CODE_W-1:0] EC_RESV_INSN  = 5'd10;
  localparam logic [CODE_W-1:0] EC_OVERFLOW   = 5'd12;

  typedef struct packed {
    logic              take;
    logic [CODE_W-1:0] code;
    logic              addr_err;
  } entry_t;
endpackage

// File: rtl/exc_arb.sv
module exc_arb import exc_pkg::*; #(
  parameter int N_HW = 5
) (
  input  logic              sync_req,
  input  logic [CODE_W-1:0] sync_code,
  input  logic              ie_cur,
  input  logic [N_HW-1:0]   hw_mask,
  input  logic [N_HW-1:0]   pend,
  output entry_t            decision
);
  logic irq_hit;

  always_comb begin
    irq_hit           = ie_cur && ((pend & hw_mask) != '0);
    decision.take     = sync_req || irq_hit;
    decision.code     = sync_req ? sync_code : EC_EXT_INT;
    decision.addr_err = sync_req &&
                        ((sync_code == EC_ADDR_LOAD) || (sync_code == EC_ADDR_STORE));
  end
endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack import exc_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               rfe,
  input  logic               wr_en,
  input  logic [MASK_W-1:0]  wr_mask,
  input  logic [STACK_W-1:0] wr_stack,
  output logic [MASK_W-1:0]  mask_q,
  output logic [STACK_W-1:0] stack_q
);
  // Each level of the stack is a {user, enable} pair; level 0 is current.
  localparam int LVL_W = 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else if (take) begin
      stack_q <= {stack_q[STACK_W-LVL_W-1:0], {LVL_W{1'b0}}};
    end else if (rfe) begin
      stack_q <= {stack_q[STACK_W-1 -: LVL_W], stack_q[STACK_W-1:LVL_W]};
    end else if (wr_en) begin
      mask_q  <= wr_mask;
      stack_q <= wr_stack;
    end
  end
endmodule

// File: rtl/exc_cause_pend.sv
module exc_cause_pend import exc_pkg::*; #(
  parameter int N_HW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              clr_en,
  input  logic [N_HW-1:0]   clr_bits,
  output logic [CODE_W-1:0] code_q,
  output logic [N_HW-1:0]   pend_q
);
  for (genvar i = 0; i < N_HW; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)                        pend_q[i] <= 1'b0;
      else if (hw_irq[i])             pend_q[i] <= 1'b1;
      else if (clr_en && clr_bits[i]) pend_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (take) code_q <= code;
  end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs import exc_pkg::*; #(
  parameter int                DATA_W   = 32,
  parameter int                N_HW     = 5,
  parameter int                SEL_W    = 5,
  parameter logic [DATA_W-1:0] VEC_ADDR = 32'h8000_0180,
  parameter logic [DATA_W-1:0] PC_STEP  = 32'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_req,
  input  logic [CODE_W-1:0] sync_code,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] fault_addr,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              rfe,
  input  logic              csr_wr,
  input  logic [SEL_W-1:0]  csr_wsel,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic [SEL_W-1:0]  csr_rsel,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              take_exc,
  output logic [DATA_W-1:0] redirect_pc
);
  logic [MASK_W-1:0]  mask_q;
  logic [STACK_W-1:0] stack_q;
  logic [CODE_W-1:0]  code_q;
  logic [N_HW-1:0]    pend_q;
  logic [DATA_W-1:0]  epc_q, bad_q, status_q, cause_q, rd_mux;
  logic               ie_cur, wr_status, wr_cause, wr_epc;
  entry_t             dec;

  assign ie_cur    = stack_q[0];
  assign wr_status = csr_wr && (csr_wsel == SEL_W'(SEL_STATUS));
  assign wr_cause  = csr_wr && (csr_wsel == SEL_W'(SEL_CAUSE));
  assign wr_epc    = csr_wr && (csr_wsel == SEL_W'(SEL_EPC));

  exc_arb #(.N_HW(N_HW)) u_arb (
    .sync_req  (sync_req),
    .sync_code (sync_code),
    .ie_cur    (ie_cur),
    .hw_mask   (mask_q[HW_MASK_LO +: N_HW]),
    .pend      (pend_q),
    .decision  (dec)
  );

  exc_status_stack u_status (
    .clk      (clk),
    .rst      (rst),
    .take     (dec.take),
    .rfe      (rfe),
    .wr_en    (wr_status),
    .wr_mask  (csr_wdata[MASK_LO +: MASK_W]),
    .wr_stack (csr_wdata[STACK_W-1:0]),
    .mask_q   (mask_q),
    .stack_q  (stack_q)
  );

  exc_cause_pend #(.N_HW(N_HW)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .take     (dec.take),
    .code     (dec.code),
    .hw_irq   (hw_irq),
    .clr_en   (wr_cause),
    .clr_bits (csr_wdata[PEND_LO +: N_HW]),
    .code_q   (code_q),
    .pend_q   (pend_q)
  );

  always_comb begin
    status_q = '0;
    status_q[MASK_LO +: MASK_W] = mask_q;
    status_q[STACK_W-1:0]       = stack_q;
    cause_q = '0;
    cause_q[CODE_LO +: CODE_W]  = code_q;
    cause_q[PEND_LO +: N_HW]    = pend_q;
  end

  always_comb begin
    case (csr_rsel)
      SEL_W'(SEL_BADADDR): rd_mux = bad_q;
      SEL_W'(SEL_STATUS):  rd_mux = status_q;
      SEL_W'(SEL_CAUSE):   rd_mux = cause_q;
      SEL_W'(SEL_EPC):     rd_mux = epc_q;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q       <= '0;
      bad_q       <= '0;
      take_exc    <= 1'b0;
      redirect_pc <= '0;
      csr_rdata   <= '0;
    end else begin
      csr_rdata <= rd_mux;
      take_exc  <= dec.take;
      if (dec.take) begin
        epc_q       <= cur_pc - PC_STEP;
        redirect_pc <= VEC_ADDR;
      end else if (wr_epc) begin
        epc_q <= csr_wdata;
      end
      if (dec.take && dec.addr_err) bad_q <= fault_addr;
    end
  end
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk import exc_pkg::*; #(
  parameter int                DATA_W   = 32,
  parameter int                N_HW     = 5,
  parameter int                SEL_W    = 5,
  parameter logic [DATA_W-1:0] VEC_ADDR = 32'h8000_0180,
  parameter logic [DATA_W-1:0] PC_STEP  = 32'd4
) (
  input logic               clk,
  input logic               rst,
  input logic               sync_req,
  input logic [CODE_W-1:0]  sync_code,
  input logic [DATA_W-1:0]  cur_pc,
  input logic               rfe,
  input logic               csr_wr,
  input logic [SEL_W-1:0]   csr_wsel,
  input logic               take_exc,
  input logic [DATA_W-1:0]  redirect_pc,
  input logic [STACK_W-1:0] stack_q,
  input logic [CODE_W-1:0]  code_q,
  input logic [N_HW-1:0]    pend_q,
  input logic [DATA_W-1:0]  epc_q,
  input logic               ie_cur
);
  logic seen_q;
  always_ff @(posedge clk) seen_q <= !rst;

  a_r3_stack_push: assert property (@(posedge clk) disable iff (rst)
    (seen_q && take_exc) |-> (stack_q[1:0] == 2'b00 && stack_q[5:2] == $past(stack_q[3:0])));

  a_r4_epc_redirect: assert property (@(posedge clk) disable iff (rst)
    (seen_q && take_exc) |-> (redirect_pc == VEC_ADDR && epc_q == $past(cur_pc) - PC_STEP));

  a_r7_pend_sticky: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !(csr_wr && csr_wsel == SEL_W'(SEL_CAUSE))) |=> (($past(pend_q) & ~pend_q) == '0));

  a_r8_no_irq_disabled: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !sync_req && !ie_cur) |=> !take_exc);

  a_r9_stack_pop: assert property (@(posedge clk) disable iff (rst)
    (seen_q && rfe && !sync_req && !ie_cur) |=>
      (stack_q[3:0] == $past(stack_q[5:2]) && stack_q[5:4] == $past(stack_q[5:4])));

  a_r10_sync_wins: assert property (@(posedge clk) disable iff (rst)
    (seen_q && sync_req) |=> (take_exc && code_q == $past(sync_code)));
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(
  .DATA_W(DATA_W), .N_HW(N_HW), .SEL_W(SEL_W), .VEC_ADDR(VEC_ADDR), .PC_STEP(PC_STEP)
) u_chk (
  .clk(clk), .rst(rst), .sync_req(sync_req), .sync_code(sync_code), .cur_pc(cur_pc),
  .rfe(rfe), .csr_wr(csr_wr), .csr_wsel(csr_wsel), .take_exc(take_exc),
  .redirect_pc(redirect_pc), .stack_q(stack_q), .code_q(code_q), .pend_q(pend_q),
  .epc_q(epc_q), .ie_cur(ie_cur)
);

// File: tb/exc_ctrl_regs_bench.sv
module exc_ctrl_regs_bench;
  logic        clk = 0, rst = 1;
  logic        sync_req = 0, rfe = 0, csr_wr = 0;
  logic [4:0]  sync_code = 0, hw_irq = 0, csr_wsel = 0, csr_rsel = 0;
  logic [31:0] cur_pc = 0, fault_addr = 0, csr_wdata = 0;
  logic [31:0] csr_rdata, redirect_pc;
  logic        take_exc;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  exc_ctrl_regs u_exc_ctrl_regs (.*);

  // Behavioural reference model
  logic [7:0]  m_mask;  logic [5:0] m_stk; logic [4:0] m_code, m_pend;
  logic [31:0] m_epc, m_bad, m_rd, m_redir; logic m_take;

  function automatic logic [31:0] m_read(input logic [4:0] s);
    case (s)
      5'd8:  return m_bad;
      5'd12: return {16'h0, m_mask, 2'b00, m_stk};
      5'd13: return {16'h0, 1'b0, m_pend, 3'b000, m_code, 2'b00};
      5'd14: return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask = 0; m_stk = 0; m_code = 0; m_pend = 0; m_epc = 0; m_bad = 0;
      m_rd = 0; m_redir = 0; m_take = 0;
    end else begin
      logic irq, tk;
      m_rd = m_read(csr_rsel);
      irq  = m_stk[0] && ((m_pend & m_mask[6:2]) != 0);
      tk   = sync_req || irq;
      if (csr_wr && csr_wsel == 13) m_pend = m_pend & ~csr_wdata[14:10];
      m_pend = m_pend | hw_irq;
      if (tk) begin
        m_stk  = {m_stk[3:0], 2'b00};
        m_code = sync_req ? sync_code : 5'd0;
        m_epc  = cur_pc - 32'd4;
        if (sync_req && (sync_code == 4 || sync_code == 5)) m_bad = fault_addr;
        m_redir = 32'h8000_0180;
      end else begin
        if (rfe) m_stk = {m_stk[5:4], m_stk[5:2]};
        else if (csr_wr && csr_wsel == 12) begin
          m_mask = csr_wdata[15:8]; m_stk = csr_wdata[5:0];
        end
        if (csr_wr && csr_wsel == 14) m_epc = csr_wdata;
      end
      m_take = tk;
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk({tag, " model take"}, {31'h0, take_exc}, {31'h0, m_take});
    chk({tag, " model redirect"}, redirect_pc, m_redir);
    chk({tag, " model rdata"}, csr_rdata, m_rd);
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    csr_wr = 1; csr_wsel = s; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic peek(input logic [4:0] s, input logic [31:0] exp, input string t);
    csr_rsel = s; @(negedge clk); chk(t, csr_rdata, exp);
  endtask

  task automatic fire(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] a,
                      input string t);
    sync_req = 1; sync_code = c; cur_pc = pc; fault_addr = a;
    @(negedge clk); sync_req = 0;
    chk({t, " take"}, {31'h0, take_exc}, 32'h1);
    chk({t, " redirect"}, redirect_pc, 32'h8000_0180);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    chk("R1 take after reset", {31'h0, take_exc}, 32'h0);
    peek(12, 0, "R1 status"); peek(13, 0, "R1 cause");
    peek(14, 0, "R1 epc");    peek(8, 0, "R1 badaddr");

    tag = "R2";
    wr(12, 32'hFFFF_FFFF);
    peek(12, 32'h0000_FF3F, "R2 status writable bits");

    tag = "R3";
    wr(12, 32'h0000_002D);
    fire(12, 32'h1000, 32'hDEAD, "R4 overflow");
    peek(12, 32'h0000_0034, "R3 stack shift");
    peek(14, 32'h0000_0FFC, "R4 epc");
    peek(13, 32'h0000_0030, "R5 overflow code");
    peek(8, 32'h0, "R6 badaddr untouched");

    tag = "R9";
    rfe = 1; @(negedge clk); rfe = 0;
    peek(12, 32'h0000_003D, "R9 stack pop");

    tag = "R6";
    fire(4, 32'h2000, 32'h1234_5678, "R6 load addr error");
    peek(8, 32'h1234_5678, "R6 load address captured");
    peek(13, 32'h0000_0010, "R5 code 4");
    fire(5, 32'h2100, 32'h0BAD_F00D, "R6 store addr error");
    peek(8, 32'h0BAD_F00D, "R6 store address captured");
    fire(8, 32'h2200, 32'h0000_0055, "R6 syscall");
    peek(8, 32'h0BAD_F00D, "R6 syscall keeps badaddr");
    peek(13, 32'h0000_0020, "R5 code 8");

    tag = "R7";
    hw_irq = 5'b00100; @(negedge clk); hw_irq = 0;
    peek(13, 32'h0000_1020, "R7 pending while disabled");
    chk("R7 no take while disabled", {31'h0, take_exc}, 32'h0);

    tag = "R8";
    wr(12, 32'h0000_1001);
    @(negedge clk);
    chk("R8 interrupt taken", {31'h0, take_exc}, 32'h1);
    peek(13, 32'h0000_1000, "R5 interrupt code 0");
    peek(12, 32'h0000_1004, "R3 interrupt entry");
    wr(12, 32'h0000_0001);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 masked pending not taken", {31'h0, take_exc}, 32'h0);
    end

    tag = "R7";
    wr(13, 32'h0000_1000);
    peek(13, 32'h0, "R7 write-one clears");
    hw_irq = 5'b00001; csr_wr = 1; csr_wsel = 13; csr_wdata = 32'h0000_0400;
    @(negedge clk); hw_irq = 0; csr_wr = 0;
    peek(13, 32'h0000_0400, "R7 arrival beats clear");
    wr(13, 32'h0000_0400);

    tag = "R10";
    hw_irq = 5'b00010; @(negedge clk); hw_irq = 0;
    wr(12, 32'h0000_0801);
    fire(9, 32'h3000, 32'h0, "R10 collide");
    peek(13, 32'h0000_0824, "R10 sync code kept, irq pending");
    peek(12, 32'h0000_0804, "R10 enable cleared");
    chk("R10 no second entry", {31'h0, take_exc}, 32'h0);
    wr(13, 32'h0000_0800);

    tag = "R12";
    wr(12, 32'h0000_0005);
    rfe = 1;
    fire(10, 32'h4000, 32'h0, "R12 rfe collide");
    rfe = 0;
    peek(12, 32'h0000_0014, "R12 exception beats rfe");
    peek(13, 32'h0000_0028, "R5 code 10");
    peek(14, 32'h0000_3FFC, "R4 epc second");
    csr_wr = 1; csr_wsel = 12; csr_wdata = 32'h0000_FF3F;
    fire(12, 32'h5000, 32'h0, "R12 write collide");
    csr_wr = 0;
    peek(12, 32'h0000_0010, "R12 status write discarded");
    peek(14, 32'h0000_4FFC, "R12 epc from entry");

    tag = "R9";
    rfe = 1; @(negedge clk); rfe = 0;
    peek(12, 32'h0000_0014, "R9 pop keeps old pair");

    tag = "R11";
    peek(3, 32'h0, "R11 unknown number");
    wr(14, 32'hCAFE_BABE);
    peek(14, 32'hCAFE_BABE, "R11 epc writable");
    wr(13, 32'hFFFF_FFFF);
    peek(13, 32'h0000_0030, "R5 code not writable");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule